// File: doc/BRIEF.md
# Load/Store Address Generation and Mode Decode

This unit takes a 32-bit memory instruction with its three source operand values and turns it into the fields of a memory request. It supports three ways of forming an address: base plus a sign-extended immediate, base plus a second register, and post-increment. In post-increment mode the unmodified base goes to memory and the sum is returned as a new base value, with a write strobe for the base register.

Loads carry their access size in the three-bit function field. One code of that field switches the load to register-register form, and the size then comes from a nested field higher in the word. Stores keep their size in two bits. A third bit picks register-register form, where a third operand supplies the offset. Separate opcodes mark the post-increment forms. Every result is registered and appears one clock after an accepted input.

Top module: `ldst_agen`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `out_valid`, `out_req` and `out_base_we` are 0, even if `in_valid` is 1.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1, and 0 after a cycle with `in_valid` 0.
- R3: Loads use opcode 7'b0000011, or 7'b0001011 for post-increment. Function field bits 14:12 select the access. Code 000 is byte signed, 001 halfword signed, 010 word, 100 byte unsigned and 101 halfword unsigned. Codes 011 and 110 are illegal. `out_size` is 0 for byte, 1 for halfword and 2 for word. `out_sext` is 1 only for the two signed codes.
- R4: A load with bits 14:12 equal to 111 is register-register. Its size comes from bits 30:28 through the same table as R3. Nested codes 011, 110 and 111 are illegal.
- R5: A non-post-increment load addresses rs1 plus the immediate. In immediate form the immediate is bits 31:20, sign-extended. In register-register form it is rs1 plus rs2. Sums wrap modulo 2^32.
- R6: Stores use opcode 7'b0100011, or 7'b0101011 for post-increment. Bits 13:12 give 00 byte, 01 halfword, 10 word, and 11 is illegal. A legal store sets `out_is_store` to 1, sets `out_sext` to 0 and puts rs2 on `out_wdata`. A load puts 0 on `out_wdata`.
- R7: A non-post-increment store with bit 14 clear addresses rs1 plus the sign-extended immediate {bits 31:25, bits 11:7}. With bit 14 set it addresses rs1 plus rs3.
- R8: A legal post-increment load or store puts rs1 unchanged on `out_addr`. It puts rs1 plus the selected offset (as in R5 and R7) on `out_base_val`, and sets `out_base_we` to 1.
- R9: A legal instruction with one of the plain opcodes has `out_base_we` 0 and `out_base_val` 0.
- R10: An illegal size code or any other opcode sets `out_illegal` to 1. `out_req`, `out_base_we`, `out_addr`, `out_base_val`, `out_wdata`, `out_size`, `out_sext` and `out_is_store` are then all 0.
- R11: `out_req` is 1 exactly when `out_valid` is 1 and the instruction was legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | XLEN | Base register value |
| in_rs2 | input | XLEN | Second operand: load offset or store data |
| in_rs3 | input | XLEN | Third operand: store register offset |
| out_valid | output | 1 | Result of last cycle's input |
| out_illegal | output | 1 | Instruction was not a legal load or store |
| out_req | output | 1 | Memory request strobe |
| out_is_store | output | 1 | Request is a write |
| out_size | output | 2 | 0 byte, 1 halfword, 2 word |
| out_sext | output | 1 | Load result is sign-extended |
| out_addr | output | XLEN | Memory address |
| out_wdata | output | XLEN | Store data |
| out_base_val | output | XLEN | New base register value |
| out_base_we | output | 1 | Write strobe for the base register |

## Verification
On every cycle the assertions check the one-cycle relation between `in_valid` and `out_valid`, and that an illegal result raises neither a request nor a base write. They also check that a base write only follows a post-increment opcode and always carries the old base as the address, that store data is the previous rs2, and that a request never carries the unused size code. The actual address sums, the wrap at 2^32, the sign extension of both immediate layouts and the full size and legality tables can only be shown by the bench. It sweeps every opcode class against every function code and every nested code, using operand sets chosen to cross the wrap point.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      OFF_IMM_I = 2'd0,
      OFF_IMM_S = 2'd1,
      OFF_RS2   = 2'd2,
      OFF_RS3   = 2'd3
   } off_src_e;

   typedef struct packed {
      logic      ok;
      acc_size_e size;
      logic      sext;
   } size_info_t;

   typedef struct packed {
      logic      legal;
      logic      is_store;
      logic      post;
      acc_size_e size;
      logic      sext;
      off_src_e  off_src;
   } mem_ctrl_t;

   // Shared table for the direct and the nested load size code
   function automatic size_info_t load_size_lookup(input logic [2:0] code);
      size_info_t r;
      r = '{ok: 1'b0, size: SZ_NONE, sext: 1'b0};
      unique case (code)
         3'b000: r = '{ok: 1'b1, size: SZ_BYTE, sext: 1'b1};
         3'b001: r = '{ok: 1'b1, size: SZ_HALF, sext: 1'b1};
         3'b010: r = '{ok: 1'b1, size: SZ_WORD, sext: 1'b0};
         3'b100: r = '{ok: 1'b1, size: SZ_BYTE, sext: 1'b0};
         3'b101: r = '{ok: 1'b1, size: SZ_HALF, sext: 1'b0};
         default: r = '{ok: 1'b0, size: SZ_NONE, sext: 1'b0};
      endcase
      return r;
   endfunction

   function automatic size_info_t store_size_lookup(input logic [1:0] code);
      size_info_t r;
      unique case (code)
         2'b00: r = '{ok: 1'b1, size: SZ_BYTE, sext: 1'b0};
         2'b01: r = '{ok: 1'b1, size: SZ_HALF, sext: 1'b0};
         2'b10: r = '{ok: 1'b1, size: SZ_WORD, sext: 1'b0};
         default: r = '{ok: 1'b0, size: SZ_NONE, sext: 1'b0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ldst_op_decode.sv
module ldst_op_decode
   import ldst_pkg::*;
#(
   parameter logic [6:0] LD_OPC  = 7'b0000011,
   parameter logic [6:0] LDP_OPC = 7'b0001011,
   parameter logic [6:0] ST_OPC  = 7'b0100011,
   parameter logic [6:0] STP_OPC = 7'b0101011
) (
   input  logic [6:0] opcode,
   input  logic [2:0] funct,
   input  logic [2:0] nested,
   output mem_ctrl_t  ctrl
);

   localparam logic [2:0] RR_LOAD_CODE = 3'b111;

   if (LD_OPC == LDP_OPC || ST_OPC == STP_OPC || LD_OPC == ST_OPC ||
       LDP_OPC == STP_OPC || LD_OPC == STP_OPC || LDP_OPC == ST_OPC) begin : g_opc_chk
      $error("ldst_op_decode: opcodes must be distinct");
   end

   logic       is_load_op;
   logic       is_store_op;
   logic       load_rr;
   logic [2:0] load_code;
   size_info_t ld_info;
   size_info_t st_info;

   assign is_load_op  = (opcode == LD_OPC) || (opcode == LDP_OPC);
   assign is_store_op = (opcode == ST_OPC) || (opcode == STP_OPC);
   assign load_rr     = (funct == RR_LOAD_CODE);
   assign load_code   = load_rr ? nested : funct;
   assign ld_info     = load_size_lookup(load_code);
   assign st_info     = store_size_lookup(funct[1:0]);

   always_comb begin
      ctrl = '{legal: 1'b0, is_store: 1'b0, post: 1'b0, size: SZ_NONE,
               sext: 1'b0, off_src: OFF_IMM_I};
      if (is_load_op) begin
         ctrl.legal    = ld_info.ok;
         ctrl.is_store = 1'b0;
         ctrl.post     = (opcode == LDP_OPC);
         ctrl.size     = ld_info.size;
         ctrl.sext     = ld_info.sext;
         ctrl.off_src  = load_rr ? OFF_RS2 : OFF_IMM_I;
      end else if (is_store_op) begin
         ctrl.legal    = st_info.ok;
         ctrl.is_store = 1'b1;
         ctrl.post     = (opcode == STP_OPC);
         ctrl.size     = st_info.size;
         ctrl.sext     = 1'b0;
         ctrl.off_src  = funct[2] ? OFF_RS3 : OFF_IMM_S;
      end
   end

endmodule

// File: rtl/ldst_imm_gen.sv
module ldst_imm_gen #(
   parameter int XLEN = 32
) (
   input  logic [11:0]     i_field,
   input  logic [4:0]      s_low,
   output logic [XLEN-1:0] imm_i,
   output logic [XLEN-1:0] imm_s
);

   localparam int IMM_W = 12;
   localparam int EXT_W = XLEN - IMM_W;

   logic [IMM_W-1:0] raw_i;
   logic [IMM_W-1:0] raw_s;

   assign raw_i = i_field;
   assign raw_s = {i_field[11:5], s_low};

   if (XLEN < IMM_W) begin : g_w_chk
      $error("ldst_imm_gen: XLEN must hold a 12-bit immediate");
   end else if (XLEN == IMM_W) begin : g_no_ext
      assign imm_i = raw_i;
      assign imm_s = raw_s;
   end else begin : g_ext
      assign imm_i = {{EXT_W{raw_i[IMM_W-1]}}, raw_i};
      assign imm_s = {{EXT_W{raw_s[IMM_W-1]}}, raw_s};
   end

endmodule

// File: rtl/ldst_offset_adder.sv
module ldst_offset_adder #(
   parameter int XLEN      = 32,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] offset,
   output logic [XLEN-1:0] sum
);

   localparam int LO_W = XLEN / 2;
   localparam int HI_W = XLEN - LO_W;

   if (XLEN < 2) begin : g_w_chk
      $error("ldst_offset_adder: XLEN too small");
   end

   if (SPLIT_ADD) begin : g_split
      // Two half-width adders with a carry between, for shorter carry chains
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_sum;
      assign lo_sum = {1'b0, base[LO_W-1:0]} + {1'b0, offset[LO_W-1:0]};
      assign hi_sum = base[XLEN-1:LO_W] + offset[XLEN-1:LO_W] + {{(HI_W-1){1'b0}}, lo_sum[LO_W]};
      assign sum    = {hi_sum, lo_sum[LO_W-1:0]};
   end else begin : g_flat
      assign sum = base + offset;
   end

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
   import ldst_pkg::*;
#(
   parameter int         XLEN      = 32,
   parameter bit         SPLIT_ADD = 1'b0,
   parameter logic [6:0] LD_OPC    = 7'b0000011,
   parameter logic [6:0] LDP_OPC   = 7'b0001011,
   parameter logic [6:0] ST_OPC    = 7'b0100011,
   parameter logic [6:0] STP_OPC   = 7'b0101011
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     in_instr,
   input  logic [XLEN-1:0] in_rs1,
   input  logic [XLEN-1:0] in_rs2,
   input  logic [XLEN-1:0] in_rs3,
   output logic            out_valid,
   output logic            out_illegal,
   output logic            out_req,
   output logic            out_is_store,
   output logic [1:0]      out_size,
   output logic            out_sext,
   output logic [XLEN-1:0] out_addr,
   output logic [XLEN-1:0] out_wdata,
   output logic [XLEN-1:0] out_base_val,
   output logic            out_base_we
);

   localparam logic [XLEN-1:0] ZERO = '0;

   mem_ctrl_t       ctrl;
   logic [XLEN-1:0] imm_i;
   logic [XLEN-1:0] imm_s;
   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] addr_c;
   logic            base_we_c;
   logic            unused_reg_index;

   // Register index fields are resolved by the register file, not here
   assign unused_reg_index = ^in_instr[19:15];

   ldst_op_decode #(
      .LD_OPC  (LD_OPC),
      .LDP_OPC (LDP_OPC),
      .ST_OPC  (ST_OPC),
      .STP_OPC (STP_OPC)
   ) i_op_decode (
      .opcode (in_instr[6:0]),
      .funct  (in_instr[14:12]),
      .nested (in_instr[30:28]),
      .ctrl   (ctrl)
   );

   ldst_imm_gen #(
      .XLEN (XLEN)
   ) i_imm_gen (
      .i_field (in_instr[31:20]),
      .s_low   (in_instr[11:7]),
      .imm_i   (imm_i),
      .imm_s   (imm_s)
   );

   always_comb begin
      unique case (ctrl.off_src)
         OFF_IMM_I: offset = imm_i;
         OFF_IMM_S: offset = imm_s;
         OFF_RS2:   offset = in_rs2;
         OFF_RS3:   offset = in_rs3;
         default:   offset = imm_i;
      endcase
   end

   ldst_offset_adder #(
      .XLEN      (XLEN),
      .SPLIT_ADD (SPLIT_ADD)
   ) i_adder (
      .base   (in_rs1),
      .offset (offset),
      .sum    (sum)
   );

   // Post-increment sends the old base out and returns the sum as new base
   assign addr_c    = ctrl.post ? in_rs1 : sum;
   assign base_we_c = ctrl.legal & ctrl.post;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_illegal  <= 1'b0;
         out_req      <= 1'b0;
         out_is_store <= 1'b0;
         out_size     <= 2'd0;
         out_sext     <= 1'b0;
         out_addr     <= ZERO;
         out_wdata    <= ZERO;
         out_base_val <= ZERO;
         out_base_we  <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & ~ctrl.legal;
         out_req     <= in_valid & ctrl.legal;
         out_base_we <= in_valid & base_we_c;
         if (in_valid) begin
            out_is_store <= ctrl.legal & ctrl.is_store;
            out_size     <= ctrl.legal ? ctrl.size : 2'd0;
            out_sext     <= ctrl.legal & ctrl.sext;
            out_addr     <= ctrl.legal ? addr_c : ZERO;
            out_wdata    <= (ctrl.legal & ctrl.is_store) ? in_rs2 : ZERO;
            out_base_val <= base_we_c ? sum : ZERO;
         end
      end
   end

endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
   parameter int         XLEN    = 32,
   parameter logic [6:0] LDP_OPC = 7'b0001011,
   parameter logic [6:0] STP_OPC = 7'b0101011
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [6:0]      in_opc,
   input logic [XLEN-1:0] in_rs1,
   input logic [XLEN-1:0] in_rs2,
   input logic            out_valid,
   input logic            out_illegal,
   input logic            out_req,
   input logic            out_is_store,
   input logic [1:0]      out_size,
   input logic [XLEN-1:0] out_addr,
   input logic [XLEN-1:0] out_wdata,
   input logic            out_base_we
);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (!out_req && !out_base_we && out_valid));

   // R11
   req_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_req |-> (out_valid && !out_illegal));

   // R8
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_base_we |-> (out_req && out_addr == $past(in_rs1)));

   // R9
   base_we_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_base_we |-> ($past(in_opc) == LDP_OPC || $past(in_opc) == STP_OPC));

   // R6
   store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && out_is_store) |-> (out_wdata == $past(in_rs2)));

   // R3
   size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_req |-> (out_size != 2'd3));

endmodule

bind ldst_agen ldst_agen_chk #(
   .XLEN    (XLEN),
   .LDP_OPC (LDP_OPC),
   .STP_OPC (STP_OPC)
) i_ldst_agen_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_opc       (in_instr[6:0]),
   .in_rs1       (in_rs1),
   .in_rs2       (in_rs2),
   .out_valid    (out_valid),
   .out_illegal  (out_illegal),
   .out_req      (out_req),
   .out_is_store (out_is_store),
   .out_size     (out_size),
   .out_addr     (out_addr),
   .out_wdata    (out_wdata),
   .out_base_we  (out_base_we)
);

// File: tb/test_ldst_agen.sv
module test_ldst_agen;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     in_instr = '0;
   logic [XLEN-1:0] in_rs1 = '0;
   logic [XLEN-1:0] in_rs2 = '0;
   logic [XLEN-1:0] in_rs3 = '0;
   logic            out_valid, out_illegal, out_req, out_is_store, out_sext, out_base_we;
   logic [1:0]      out_size;
   logic [XLEN-1:0] out_addr, out_wdata, out_base_val;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   logic [31:0] rng = 32'h1234_5679;

   typedef struct {
      bit          legal;
      bit          is_load;
      bit          rr;
      bit          is_store;
      bit          post;
      logic [1:0]  size;
      bit          sext;
      logic [31:0] addr;
      logic [31:0] wdata;
      bit          base_we;
      logic [31:0] base_val;
   } exp_t;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_agen i_ldst_agen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rs3(in_rs3),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_req(out_req),
      .out_is_store(out_is_store), .out_size(out_size), .out_sext(out_sext),
      .out_addr(out_addr), .out_wdata(out_wdata), .out_base_val(out_base_val),
      .out_base_we(out_base_we)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // Reference model written from the requirement list
   function automatic exp_t model(input logic [31:0] ins, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] c);
      exp_t e;
      logic [2:0]  code;
      logic [31:0] off;
      e = '{default: 0};
      off = 32'd0;
      if (ins[6:0] == 7'b0000011 || ins[6:0] == 7'b0001011) begin
         e.is_load = 1'b1;
         e.post    = (ins[6:0] == 7'b0001011);
         e.rr      = (ins[14:12] == 3'b111);
         code      = e.rr ? ins[30:28] : ins[14:12];
         e.legal   = 1'b1;
         case (code)
            3'd0: begin e.size = 2'd0; e.sext = 1'b1; end
            3'd1: begin e.size = 2'd1; e.sext = 1'b1; end
            3'd2: e.size = 2'd2;
            3'd4: e.size = 2'd0;
            3'd5: e.size = 2'd1;
            default: e.legal = 1'b0;
         endcase
         off = e.rr ? b : {{20{ins[31]}}, ins[31:20]};
      end else if (ins[6:0] == 7'b0100011 || ins[6:0] == 7'b0101011) begin
         e.is_store = 1'b1;
         e.post     = (ins[6:0] == 7'b0101011);
         e.rr       = ins[14];
         e.legal    = (ins[13:12] != 2'b11);
         e.size     = ins[13:12];
         e.wdata    = b;
         off = e.rr ? c : {{20{ins[31]}}, ins[31:25], ins[11:7]};
      end
      e.addr     = e.post ? a : a + off;
      e.base_we  = e.post;
      e.base_val = e.post ? a + off : 32'd0;
      if (!e.legal) begin
         e.is_store = 1'b0; e.post = 1'b0; e.size = 2'd0; e.sext = 1'b0;
         e.addr = '0; e.wdata = '0; e.base_we = 1'b0; e.base_val = '0;
      end
      return e;
   endfunction

   task automatic run_one(input logic [31:0] ins, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] c);
      exp_t  e;
      string t_size, t_addr, t_base;
      e = model(ins, a, b, c);
      in_valid = 1'b1; in_instr = ins; in_rs1 = a; in_rs2 = b; in_rs3 = c;
      @(negedge clk);
      if (!e.legal)        begin t_size = "R10"; t_addr = "R10"; end
      else if (e.is_store) begin t_size = "R6";  t_addr = e.post ? "R8" : "R7"; end
      else                 begin t_size = e.rr ? "R4" : "R3"; t_addr = e.post ? "R8" : "R5"; end
      t_base = e.post ? "R8" : (e.legal ? "R9" : "R10");
      chk(out_valid == 1'b1, "R2 valid", {31'd0, out_valid}, 32'd1);
      chk(out_illegal == !e.legal, "R10 illegal", {31'd0, out_illegal}, {31'd0, !e.legal});
      chk(out_req == e.legal, "R11 req", {31'd0, out_req}, {31'd0, e.legal});
      chk(out_is_store == e.is_store, "R6 is_store", {31'd0, out_is_store}, {31'd0, e.is_store});
      chk(out_size == e.size, {t_size, " size"}, {30'd0, out_size}, {30'd0, e.size});
      chk(out_sext == e.sext, {t_size, " sext"}, {31'd0, out_sext}, {31'd0, e.sext});
      chk(out_addr == e.addr, {t_addr, " addr"}, out_addr, e.addr);
      chk(out_wdata == e.wdata, "R6 wdata", out_wdata, e.wdata);
      chk(out_base_we == e.base_we, {t_base, " base_we"}, {31'd0, out_base_we}, {31'd0, e.base_we});
      chk(out_base_val == e.base_val, {t_base, " base_val"}, out_base_val, e.base_val);
   endtask

   initial begin
      // R1: reset holds outputs low even with a valid input presented
      in_valid = 1'b1;
      in_instr = 32'h0000_2003;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", {31'd0, out_valid}, 32'd0);
      chk(out_req == 1'b0, "R1 req in reset", {31'd0, out_req}, 32'd0);
      chk(out_base_we == 1'b0, "R1 base_we in reset", {31'd0, out_base_we}, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle after reset", {31'd0, out_valid}, 32'd0);

      for (int op = 0; op < 5; op++) begin
         logic [6:0] opc;
         case (op)
            0: opc = 7'b0000011;
            1: opc = 7'b0001011;
            2: opc = 7'b0100011;
            3: opc = 7'b0101011;
            default: opc = 7'b0110011;
         endcase
         for (int f3 = 0; f3 < 8; f3++) begin
            for (int nb = 0; nb < 8; nb++) begin
               for (int s = 0; s < 3; s++) begin
                  logic [31:0] ins, a, b, c;
                  rng = next_rng(rng);
                  ins = rng;
                  ins[6:0]   = opc;
                  ins[14:12] = f3[2:0];
                  ins[30:28] = nb[2:0];
                  ins[31]    = s[0] ^ nb[0];
                  rng = next_rng(rng);
                  case (s)
                     0: begin a = 32'h1000_0000; b = 32'h0000_0040; c = 32'hFFFF_FFFC; end
                     1: begin a = 32'hFFFF_FFF0; b = 32'h0000_0020; c = 32'h0000_0030; end
                     default: begin a = rng; b = next_rng(rng); c = ~rng; end
                  endcase
                  run_one(ins, a, b, c);
               end
            end
            // R2: a bubble yields no valid, request or base write
            in_valid = 1'b0;
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 bubble valid", {31'd0, out_valid}, 32'd0);
            chk(out_req == 1'b0, "R11 bubble req", {31'd0, out_req}, 32'd0);
            chk(out_base_we == 1'b0, "R9 bubble base_we", {31'd0, out_base_we}, 32'd0);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule